// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block sits beside one processor and decides which interrupt, if any, that processor is currently being asked to take. It holds a single pending slot. It fills the slot from two contenders: delivery requests arriving from an interrupt source unit, and a processor-to-processor doorbell whose priority software programs. Priorities compare numerically, and a lower value is more favored. The block drives one level interrupt line toward the CPU. It answers every delivery request with an accept or a reject pulse. When a pending interrupt is displaced or withdrawn, its source number goes back to the source unit so that the source unit can retry it later.

Software works the block through one operation port. A single operation code selects what the operation does:
- change the current processor priority,
- program the doorbell priority,
- acknowledge the pending interrupt, which reads and clears it,
- poll the state without side effects,
- end an interrupt.

The block forwards end-of-interrupt notices to the source unit. Whenever the block becomes able to take new work, it pulses a resend request. All responses are registered: an operation or request presented in one cycle shows its outputs after the next rising clock edge.

Top module: `irq_present_ctl`

## Requirements
- R1: Reset behaviour. After reset, the 32-bit presentation word reads zero. This word holds the processor priority in bits 31:24 and the pending source number in bits 23:0, and a source of zero means nothing is pending. After reset the doorbell priority is 0xff, the pending priority is 0xff and the CPU line is low.
- R2: Request rejection. A delivery request gets a `req_reject` pulse when its priority is numerically greater than or equal to the processor priority. It is also rejected when a source is already pending at a priority less than or equal to the request's priority. A rejected request leaves the state unchanged.
- R3: Request acceptance. A request that is not rejected gets a `req_accept` pulse. Its source number and priority are latched into the slot, and the CPU line rises. If the request displaces a pending interrupt that came from the source unit, that interrupt's source number is returned on `bounce_src` with a `bounce_valid` pulse.
- R4: Acknowledge (operation code 3). The operation returns the whole presentation word on `rd_data` with `rd_valid` and lowers the CPU line. The processor priority then becomes the old pending priority, the source field is cleared and the pending priority returns to 0xff.
- R5: Tightening the processor priority (operation code 1, new value in bits 7:0). The new value may be more favored than the old one while a source is pending whose priority is numerically greater than or equal to the new value. In that case the source field is cleared, the line falls and an owned source is bounced. Otherwise the pending source stays.
- R6: Relaxing the processor priority. Writing a value equal to or less favored than the current one while nothing is pending pulses `resend`. If a source is pending, no resend is raised.
- R7: Doorbell (operation code 2, priority in bits 7:0). The new doorbell priority is stored. The doorbell is evaluated only when this priority is below the processor priority. During evaluation it loses to a pending source whose priority is less than or equal to its own. Otherwise it takes the slot with source number 2 and the doorbell priority, and raises the line; an owned pending source is bounced first. A doorbell that gets displaced is never bounced.
- R8: End of interrupt (operation code 5). Bits 31:24 of the data replace the processor priority, and bits 23:0 go out on `eoi_src` with an `eoi_valid` pulse. If nothing is pending, `resend` pulses. In that case the doorbell is also evaluated first when its priority is below the new processor priority.
- R9: Poll (operation code 4). The operation returns the presentation word on `rd_data` and the doorbell priority on `rd_db`, and changes no state and no other output.
- R10: Collision. When a software operation and a delivery request arrive in the same cycle, the operation takes effect first and the request receives no answer in that cycle. The request is evaluated in the next cycle that carries no operation, against the state the operation left behind.
- R11: Line consistency. The CPU line is high exactly when the source field of the presentation word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Delivery request from the source unit |
| req_src | input | 24 | Source number of the request |
| req_prio | input | 8 | Priority of the request |
| req_accept | output | 1 | Pulse: request latched |
| req_reject | output | 1 | Pulse: request refused |
| op_valid | input | 1 | Software operation present |
| op_kind | input | 3 | Operation code (1 priority, 2 doorbell, 3 acknowledge, 4 poll, 5 end of interrupt) |
| op_data | input | 32 | Operation data word |
| rd_valid | output | 1 | Pulse: read data valid (acknowledge or poll) |
| rd_data | output | 32 | Presentation word returned |
| rd_db | output | 8 | Doorbell priority returned |
| bounce_valid | output | 1 | Pulse: pending source returned to the source unit |
| bounce_src | output | 24 | Source number returned |
| eoi_valid | output | 1 | Pulse: end-of-interrupt notice |
| eoi_src | output | 24 | Source number being ended |
| resend | output | 1 | Pulse: source unit may retry deferred work |
| cpu_irq | output | 1 | Interrupt line to the processor |

## Verification
The properties assume that the source unit keeps at most one request unanswered. In particular, it issues no new request in the cycle after a collision, while the deferred one is still held. They also assume that requests never carry source number zero or the doorbell number. The directed stimulus drops `req_valid` after every request and waits for the answer pulse before issuing the next one. After a collision it leaves the request lines idle for the deferral cycle. All source numbers it uses lie well away from 0 and 2.

// File: rtl/irq_present_pkg.sv
package irq_present_pkg;

    localparam int SRC_W  = 24;
    localparam int PRIO_W = 8;
    localparam int XR_W   = PRIO_W + SRC_W;
    localparam int OP_W   = 3;

    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [XR_W-1:0]   xr_t;

    localparam prio_t PRIO_OFF = '1;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE     = 3'd0,
        OP_SET_PRIO = 3'd1,
        OP_SET_DB   = 3'd2,
        OP_ACK      = 3'd3,
        OP_POLL     = 3'd4,
        OP_EOI      = 3'd5
    } op_kind_e;

    // Presentation slot: processor priority, pending source and its priority,
    // whether the pending source belongs to the source unit, and the line.
    typedef struct packed {
        prio_t cpri;
        src_t  src;
        prio_t ppri;
        logic  owned;
        logic  line;
    } slot_t;

    typedef struct packed {
        logic  valid;
        src_t  src;
        prio_t prio;
    } req_t;

    typedef struct packed {
        logic valid;
        src_t src;
    } note_t;

    function automatic xr_t pack_xr(slot_t s);
        return {s.cpri, s.src};
    endfunction

    function automatic logic slot_busy(slot_t s);
        return s.src != '0;
    endfunction

    function automatic slot_t slot_reset();
        slot_t s;
        s.cpri  = '0;
        s.src   = '0;
        s.ppri  = PRIO_OFF;
        s.owned = 1'b0;
        s.line  = 1'b0;
        return s;
    endfunction

    function automatic slot_t slot_cleared(slot_t s);
        slot_t r = s;
        r.src   = '0;
        r.ppri  = PRIO_OFF;
        r.owned = 1'b0;
        r.line  = 1'b0;
        return r;
    endfunction

    // Doorbell wins unless a pending source is at least as favored.
    function automatic logic db_wins(slot_t s, prio_t db);
        return !(slot_busy(s) && (s.ppri <= db));
    endfunction

    function automatic slot_t db_latch(slot_t s, prio_t db, src_t id);
        slot_t r = s;
        r.src   = id;
        r.ppri  = db;
        r.owned = 1'b0;
        r.line  = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/irq_req_hold.sv
module irq_req_hold
    import irq_present_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  src_t  req_src,
    input  prio_t req_prio,
    input  logic  stall,
    output req_t  eff
);
    req_t held_q;

    always_comb begin
        if (held_q.valid) begin
            eff = held_q;
        end else begin
            eff.valid = req_valid;
            eff.src   = req_src;
            eff.prio  = req_prio;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (eff.valid && stall) begin
            held_q <= eff;
        end else begin
            held_q <= '0;
        end
    end
endmodule

// File: rtl/irq_slot_eval.sv
module irq_slot_eval
    import irq_present_pkg::*;
#(
    parameter src_t DB_ID = 24'd2
) (
    input  slot_t          cur,
    input  prio_t          db,
    input  logic           op_valid,
    input  logic [OP_W-1:0] op_kind,
    input  xr_t            op_data,
    input  req_t           req,
    output slot_t          nxt,
    output prio_t          nxt_db,
    output note_t          bounce,
    output note_t          eoi,
    output logic           resend,
    output logic           accept,
    output logic           reject,
    output logic           rd_valid,
    output xr_t            rd_data
);
    op_kind_e kind;
    prio_t    lo;
    prio_t    hi;

    always_comb begin
        kind     = op_kind_e'(op_kind);
        lo       = op_data[PRIO_W-1:0];
        hi       = op_data[XR_W-1:SRC_W];
        nxt      = cur;
        nxt_db   = db;
        bounce   = '0;
        eoi      = '0;
        resend   = 1'b0;
        accept   = 1'b0;
        reject   = 1'b0;
        rd_valid = 1'b0;
        rd_data  = pack_xr(cur);

        if (op_valid) begin
            case (kind)
                OP_SET_PRIO: begin
                    nxt.cpri = lo;
                    if (lo < cur.cpri) begin
                        if (slot_busy(cur) && (lo <= cur.ppri)) begin
                            nxt = slot_cleared(nxt);
                            if (cur.owned) bounce = '{valid: 1'b1, src: cur.src};
                        end
                    end else if (!slot_busy(cur)) begin
                        resend = 1'b1;
                        if (db < lo) nxt = db_latch(nxt, db, DB_ID);
                    end
                end
                OP_SET_DB: begin
                    nxt_db = lo;
                    if ((lo < cur.cpri) && db_wins(cur, lo)) begin
                        if (slot_busy(cur) && cur.owned)
                            bounce = '{valid: 1'b1, src: cur.src};
                        nxt = db_latch(cur, lo, DB_ID);
                    end
                end
                OP_ACK: begin
                    rd_valid = 1'b1;
                    nxt      = slot_cleared(cur);
                    nxt.cpri = cur.ppri;
                end
                OP_POLL: begin
                    rd_valid = 1'b1;
                end
                OP_EOI: begin
                    nxt.cpri = hi;
                    eoi      = '{valid: 1'b1, src: op_data[SRC_W-1:0]};
                    if (!slot_busy(cur)) begin
                        resend = 1'b1;
                        if (db < hi) nxt = db_latch(nxt, db, DB_ID);
                    end
                end
                default: ;
            endcase
        end else if (req.valid) begin
            if ((req.prio >= cur.cpri) || (slot_busy(cur) && (cur.ppri <= req.prio))) begin
                reject = 1'b1;
            end else begin
                accept = 1'b1;
                if (slot_busy(cur) && cur.owned)
                    bounce = '{valid: 1'b1, src: cur.src};
                nxt.src   = req.src;
                nxt.ppri  = req.prio;
                nxt.owned = 1'b1;
                nxt.line  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_present_ctl.sv
module irq_present_ctl
    import irq_present_pkg::*;
#(
    parameter int unsigned DOORBELL_ID = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [PRIO_W-1:0] req_prio,
    output logic              req_accept,
    output logic              req_reject,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_kind,
    input  logic [XR_W-1:0]   op_data,
    output logic              rd_valid,
    output logic [XR_W-1:0]   rd_data,
    output logic [PRIO_W-1:0] rd_db,
    output logic              bounce_valid,
    output logic [SRC_W-1:0]  bounce_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend,
    output logic              cpu_irq
);
    localparam src_t DB_ID = src_t'(DOORBELL_ID);

    slot_t slot_q, slot_d;
    prio_t db_q, db_d;
    req_t  eff_req;
    note_t bn_d, eoi_d;
    logic  rs_d, acc_d, rej_d, rdv_d;
    xr_t   rdd_d;
    src_t  src_q;

    assign src_q   = slot_q.src;
    assign cpu_irq = slot_q.line;

    irq_req_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_src   (req_src),
        .req_prio  (req_prio),
        .stall     (op_valid),
        .eff       (eff_req)
    );

    irq_slot_eval #(.DB_ID(DB_ID)) u_eval (
        .cur      (slot_q),
        .db       (db_q),
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .op_data  (op_data),
        .req      (eff_req),
        .nxt      (slot_d),
        .nxt_db   (db_d),
        .bounce   (bn_d),
        .eoi      (eoi_d),
        .resend   (rs_d),
        .accept   (acc_d),
        .reject   (rej_d),
        .rd_valid (rdv_d),
        .rd_data  (rdd_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q       <= slot_reset();
            db_q         <= PRIO_OFF;
            req_accept   <= 1'b0;
            req_reject   <= 1'b0;
            rd_valid     <= 1'b0;
            rd_data      <= '0;
            rd_db        <= PRIO_OFF;
            bounce_valid <= 1'b0;
            bounce_src   <= '0;
            eoi_valid    <= 1'b0;
            eoi_src      <= '0;
            resend       <= 1'b0;
        end else begin
            slot_q       <= slot_d;
            db_q         <= db_d;
            req_accept   <= acc_d;
            req_reject   <= rej_d;
            rd_valid     <= rdv_d;
            rd_data      <= rdd_d;
            rd_db        <= db_q;
            bounce_valid <= bn_d.valid;
            bounce_src   <= bn_d.src;
            eoi_valid    <= eoi_d.valid;
            eoi_src      <= eoi_d.src;
            resend       <= rs_d;
        end
    end
endmodule

// File: rtl/irq_present_chk.sv
module irq_present_chk
    import irq_present_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            op_valid,
    input logic [OP_W-1:0] op_kind,
    input logic            req_accept,
    input logic            req_reject,
    input logic            rd_valid,
    input logic            eoi_valid,
    input logic            cpu_irq,
    input src_t            src_q
);
    p_one_answer_r2: assert property (@(posedge clk) disable iff (rst)
        !(req_accept && req_reject));

    p_accept_raises_r3: assert property (@(posedge clk) disable iff (rst)
        req_accept |-> cpu_irq);

    p_ack_lowers_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_ACK) |=> (!cpu_irq && rd_valid));

    p_eoi_notice_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_EOI) |=> eoi_valid);

    p_poll_still_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_POLL) |=> ($stable(cpu_irq) && $stable(src_q)));

    p_defer_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && req_valid) |=> (!req_accept && !req_reject));

    p_single_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && req_valid) |=> !req_valid);

    p_line_src_r11: assert property (@(posedge clk) disable iff (rst)
        cpu_irq == (src_q != '0));
endmodule

bind irq_present_ctl irq_present_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .req_accept (req_accept),
    .req_reject (req_reject),
    .rd_valid   (rd_valid),
    .eoi_valid  (eoi_valid),
    .cpu_irq    (cpu_irq),
    .src_q      (src_q)
);

// File: tb/irq_present_ctl_bench.sv
`timescale 1ns/1ps
module irq_present_ctl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [23:0] req_src;
    logic [7:0]  req_prio;
    logic        req_accept, req_reject;
    logic        op_valid;
    logic [2:0]  op_kind;
    logic [31:0] op_data;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [7:0]  rd_db;
    logic        bounce_valid;
    logic [23:0] bounce_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend;
    logic        cpu_irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] pd;
    logic [7:0]  pb;

    always #4 clk = ~clk;

    irq_present_ctl u_irq_present_ctl (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 1'b0; req_src = '0; req_prio = '0;
        op_valid = 1'b0; op_kind = '0; op_data = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_req(logic [23:0] s, logic [7:0] p);
        req_valid = 1'b1; req_src = s; req_prio = p;
        step();
        idle();
    endtask

    task automatic do_op(logic [2:0] k, logic [31:0] d);
        op_valid = 1'b1; op_kind = k; op_data = d;
        step();
        idle();
    endtask

    task automatic poll(output logic [31:0] d, output logic [7:0] b);
        do_op(3'd4, '0);
        d = rd_data;
        b = rd_db;
    endtask

    task automatic t_reset();
        check("R1 line low in reset", cpu_irq, 0);
        @(negedge clk) rst = 1'b0;
        poll(pd, pb);
        check("R1 word after reset", pd, 32'h0);
        check("R1 doorbell after reset", pb, 8'hff);
        do_op(3'd3, '0);
        check("R4 ack returns zero word", rd_data, 32'h0);
        poll(pd, pb);
        check("R1 pending priority ff via ack", pd, 32'hff000000);
    endtask

    task automatic t_accept_reject();
        do_req(24'h10, 8'd5);
        check("R3 accept", {req_accept, req_reject, bounce_valid}, 3'b100);
        check("R11 line after accept", cpu_irq, 1);
        poll(pd, pb);
        check("R3 latched word", pd, 32'hff000010);
        do_req(24'h11, 8'd5);
        check("R2 equal to pending rejected", {req_accept, req_reject}, 2'b01);
        do_req(24'h11, 8'd7);
        check("R2 worse than pending rejected", {req_accept, req_reject}, 2'b01);
        poll(pd, pb);
        check("R2 state unchanged", pd, 32'hff000010);
        do_req(24'h12, 8'd3);
        check("R3 displacing accept", {req_accept, bounce_valid}, 2'b11);
        check("R3 bounced source", bounce_src, 24'h10);
    endtask

    task automatic t_ack();
        do_op(3'd3, '0);
        check("R4 ack word", rd_data, 32'hff000012);
        check("R4 ack lowers line", cpu_irq, 0);
        poll(pd, pb);
        check("R4 priority from pending", pd, 32'h03000000);
        do_req(24'h13, 8'd3);
        check("R2 equal to processor priority rejected", req_reject, 1);
        do_req(24'h20, 8'd2);
        check("R2 more favored accepted", req_accept, 1);
    endtask

    task automatic t_set_prio();
        do_op(3'd1, 32'h2);
        check("R5 withdraw bounce", {bounce_valid, bounce_src}, {1'b1, 24'h20});
        check("R5 line low", cpu_irq, 0);
        poll(pd, pb);
        check("R5 cleared word", pd, 32'h02000000);
        do_op(3'd1, 32'h1);
        check("R6 tighten idle no resend", resend, 0);
        do_op(3'd1, 32'hff);
        check("R6 relax idle resend", resend, 1);
        do_req(24'h30, 8'd1);
        do_op(3'd1, 32'h4);
        check("R5 keep more favored pending", {bounce_valid, cpu_irq}, 2'b01);
        poll(pd, pb);
        check("R5 word kept", pd, 32'h04000030);
        do_op(3'd1, 32'hff);
        check("R6 relax busy no resend", resend, 0);
        do_op(3'd3, '0);
        do_op(3'd1, 32'hff);
        check("R6 resend after clear", resend, 1);
    endtask

    task automatic t_doorbell();
        do_req(24'h40, 8'd6);
        do_op(3'd2, 32'h6);
        check("R7 equal doorbell loses", bounce_valid, 0);
        poll(pd, pb);
        check("R7 word unchanged", pd, 32'hff000040);
        check("R7 doorbell stored", pb, 8'h06);
        do_op(3'd2, 32'h5);
        check("R7 doorbell bounces owned", {bounce_valid, bounce_src}, {1'b1, 24'h40});
        poll(pd, pb);
        check("R7 doorbell in slot", pd, 32'hff000002);
        do_req(24'h41, 8'd4);
        check("R7 displaced doorbell not bounced", {req_accept, bounce_valid}, 2'b10);
        do_op(3'd3, '0);
        check("R4 ack word 41", rd_data, 32'hff000041);
        do_op(3'd2, 32'hff);
        check("R7 masked doorbell no line", cpu_irq, 0);
    endtask

    task automatic t_eoi();
        do_op(3'd5, 32'hff000041);
        check("R8 eoi notice", {eoi_valid, eoi_src}, {1'b1, 24'h41});
        check("R8 resend when idle", resend, 1);
        poll(pd, pb);
        check("R8 priority replaced", pd, 32'hff000000);
        do_op(3'd2, 32'h7);
        do_op(3'd3, '0);
        check("R7 idle doorbell taken", rd_data, 32'hff000002);
        do_op(3'd5, 32'hff000002);
        check("R8 doorbell re-evaluated", {resend, cpu_irq}, 2'b11);
        poll(pd, pb);
        check("R8 doorbell word", pd, 32'hff000002);
        do_op(3'd3, '0);
        do_op(3'd2, 32'hff);
        do_req(24'h50, 8'd3);
        do_op(3'd5, 32'hff000099);
        check("R8 busy eoi", {eoi_valid, eoi_src, resend}, {1'b1, 24'h99, 1'b0});
    endtask

    task automatic t_poll();
        logic [31:0] d1;
        logic [7:0]  b1;
        poll(d1, b1);
        check("R9 no pulses", {req_accept, req_reject, bounce_valid, eoi_valid, resend}, 5'b0);
        poll(pd, pb);
        check("R9 word stable", pd, d1);
        check("R9 doorbell stable", pb, b1);
        check("R9 line stable", cpu_irq, 1);
    endtask

    task automatic t_collide();
        op_valid = 1'b1; op_kind = 3'd4;
        req_valid = 1'b1; req_src = 24'h60; req_prio = 8'd2;
        step();
        idle();
        check("R10 op first, no answer", {rd_valid, req_accept, req_reject}, 3'b100);
        check("R10 poll sees old word", rd_data, 32'hff000050);
        step();
        check("R10 deferred accept", {req_accept, bounce_valid, bounce_src}, {2'b11, 24'h50});
        op_valid = 1'b1; op_kind = 3'd1; op_data = 32'h1;
        req_valid = 1'b1; req_src = 24'h61; req_prio = 8'd1;
        step();
        idle();
        check("R10 op withdraws first", {bounce_valid, bounce_src, req_reject}, {1'b1, 24'h60, 1'b0});
        step();
        check("R10 deferred judged on new priority", {req_accept, req_reject}, 2'b01);
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_accept_reject();
        t_ack();
        t_set_prio();
        t_doorbell();
        t_eoi();
        t_poll();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule